// File: doc/BRIEF.md
# Interleaved Configuration Image Extractor

This block takes one byte stream that carries several configuration images woven together in fixed-size chunks, one chunk from each image in turn. It keeps only the chunks of the image chosen at start. Bytes from the other images are taken in and thrown away. The kept bytes must open with a fixed 13-byte signature. After the signature comes a run of header sections. Each section has a one-letter type, a big-endian length and that many content bytes. The block walks these sections until it meets the payload section, which is type `e`. It reports that section's 32-bit length and then passes exactly that many following bytes out as payload.

A controller sets `img_sel` (1-based) and `img_count` and pulses `start` while the block is idle, finished or in error. The block then pulls bytes from the input stream until it finishes or fails. `done` or `error` then stays high, and input stays stalled, until the next `start`.

Both streams use valid/ready. A byte moves on a rising clock edge when its valid and ready are both high. The source must hold `in_data` steady while `in_valid` is high and the byte has not been taken. There is no buffering inside the block, so a payload byte is offered on `out_valid` in the same cycle it sits on the input. A low `out_ready` stalls the input only while the byte on the input is a kept payload byte. Bytes from other images are still taken at full rate. Header bytes are never held back by `out_ready`.

Top module: `cfg_image_extract`

## Requirements
- R1: Counting accepted input bytes from 0 after `start`, byte i belongs to image ((i / CHUNK_BYTES) mod img_count) + 1. While a run is in progress, a byte of any other image than `img_sel` is accepted whenever it is valid (`in_ready` high), and it never appears on the output.
- R2: The first 13 kept bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first kept byte that differs is consumed, and `error` rises on the next cycle.
- R3: After the signature, each header section is one type byte, then a big-endian length, then that many content bytes. The content is skipped. Types 'a' (0x61) to 'd' carry a 2-byte length.
- R4: A type byte below 0x61 or above 0x65 ends the run with `error`.
- R5: A 2-byte section length above 255 ends the run with `error` as soon as its second length byte is taken.
- R6: Header bytes are counted from the first byte after the signature. Once SEARCH_LIMIT (100) of them have been taken, no further type byte or content byte is accepted and `error` is raised. Length bytes of a section whose type byte came before the limit are still taken.
- R7: Type 'e' (0x65) carries a 4-byte big-endian length, which appears on `payload_length`. Exactly that many following kept bytes are sent out, in order, and then `done` rises. With a length of zero, `done` rises right after the length and nothing is sent.
- R8: `out_valid` is high only when a kept payload byte is valid on the input, and `out_data` equals `in_data`. While `out_ready` is low, that byte is not accepted.
- R9: On `start`, a configuration with `img_count` = 0, `img_sel` = 0, `img_sel` > `img_count`, or `img_count` > MAX_IMAGES raises `error` on the next cycle, and no byte is accepted.
- R10: `done` and `error` hold, and `in_ready` and `out_valid` stay low, until the next `start`. A `start` clears `payload_length` to 0 and clears `done`.
- R11: After reset, `done`, `error`, `in_ready` and `out_valid` are low and `payload_length` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that samples the configuration and begins a run |
| img_sel | input | IMG_W | Image to keep, 1-based |
| img_count | input | IMG_W | Number of interleaved images |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts payload byte |
| out_data | output | 8 | Payload byte |
| done | output | 1 | Payload fully forwarded; held until start |
| error | output | 1 | Configuration, signature or header fault; held until start |
| payload_length | output | 32 | Length taken from the payload section |

IMG_W is $clog2(MAX_IMAGES+1).

## Verification
The assertions rely on the input source holding `in_data` steady while a byte waits. They also rely on `start` being pulsed only while no run is in progress, because a `start` in the middle of a run discards the byte on the input. The bench keeps to both rules. It changes inputs only on falling edges, raises `start` only after `done` or `error` has been seen, and takes every input byte from a fixed function of its stream index, so a stalled byte never changes. Valid and ready patterns are throttled in several ways, and configurations stay within MAX_IMAGES except in the cases that test R9 on purpose.

// File: rtl/imgsel_pkg.sv
`timescale 1ns/1ps
package imgsel_pkg;

  localparam int SIG_BYTES  = 13;
  localparam int PLEN_W     = 32;
  localparam logic [7:0] SEC_TYPE_LO  = 8'h61;
  localparam logic [7:0] SEC_TYPE_HI  = 8'h65;
  localparam logic [7:0] SEC_TYPE_PAY = 8'h65;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_SIG,
    WK_TYPE,
    WK_LEN,
    WK_SKIP,
    WK_PAY,
    WK_DONE,
    WK_ERR
  } walk_state_t;

  // Expected signature byte at a given position.
  function automatic logic [7:0] sig_byte(input logic [3:0] idx);
    logic [7:0] b;
    if (idx == 4'd1)
      b = 8'h09;
    else if (idx >= 4'd2 && idx <= 4'd9)
      b = idx[0] ? 8'hF0 : 8'h0F;
    else if (idx == 4'd12)
      b = 8'h01;
    else
      b = 8'h00;
    return b;
  endfunction

endpackage

// File: rtl/imgsel_chunk_filter.sv
`timescale 1ns/1ps
module imgsel_chunk_filter #(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 4,
  localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1,
  localparam int IMG_W = $clog2(MAX_IMAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IMG_W-1:0] sel_in,
  input  logic [IMG_W-1:0] count_in,
  input  logic             beat,
  output logic             keep
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHUNK_BYTES - 1);

  logic [POS_W-1:0] pos_q;
  logic [IMG_W-1:0] slot_q;
  logic [IMG_W-1:0] sel_q;
  logic [IMG_W-1:0] cnt_q;
  logic             slot_wrap;

  assign slot_wrap = (slot_q == cnt_q - IMG_W'(1));
  assign keep      = (slot_q == sel_q - IMG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else if (restart) begin
      pos_q  <= '0;
      slot_q <= '0;
      sel_q  <= sel_in;
      cnt_q  <= count_in;
    end else if (beat) begin
      if (pos_q == POS_LAST) begin
        pos_q  <= '0;
        slot_q <= slot_wrap ? '0 : slot_q + IMG_W'(1);
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/imgsel_pay_count.sv
`timescale 1ns/1ps
module imgsel_pay_count #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [LEN_W-1:0] rem_q;

  assign last = (rem_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (load)
      rem_q <= load_val;
    else if (dec)
      rem_q <= rem_q - LEN_W'(1);
  end

endmodule

// File: rtl/imgsel_hdr_walker.sv
`timescale 1ns/1ps
module imgsel_hdr_walker
  import imgsel_pkg::*;
#(
  parameter int SEARCH_LIMIT = 100,
  localparam int CNT_W = $clog2(SEARCH_LIMIT + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_ok,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              sink_ready,
  input  logic              pay_last,
  output logic              byte_ready,
  output logic              pay_load,
  output logic [PLEN_W-1:0] pay_len_new,
  output logic              pay_dec,
  output logic [PLEN_W-1:0] payload_len,
  output logic              active,
  output logic              in_payload,
  output logic              done,
  output logic              error
);

  walk_state_t       state_q;
  logic [3:0]        sig_idx_q;
  logic [CNT_W-1:0]  hdr_cnt_q;
  logic [23:0]       len_acc_q;
  logic [1:0]        len_left_q;
  logic              is_pay_q;
  logic [7:0]        skip_left_q;

  logic              kb;
  logic              limit_hit;
  logic              type_ok;
  logic [PLEN_W-1:0] len_next;

  assign kb        = byte_valid && byte_ready;
  assign limit_hit = (hdr_cnt_q >= CNT_W'(SEARCH_LIMIT));
  assign type_ok   = (byte_data >= SEC_TYPE_LO) && (byte_data <= SEC_TYPE_HI);
  assign len_next  = {len_acc_q, byte_data};

  always_comb begin
    case (state_q)
      WK_SIG, WK_LEN:   byte_ready = 1'b1;
      WK_TYPE, WK_SKIP: byte_ready = !limit_hit;
      WK_PAY:           byte_ready = sink_ready;
      default:          byte_ready = 1'b0;
    endcase
  end

  assign pay_load    = (state_q == WK_LEN) && kb && (len_left_q == 2'd0) && is_pay_q;
  assign pay_len_new = len_next;
  assign pay_dec     = (state_q == WK_PAY) && kb;
  assign active      = (state_q != WK_IDLE) && (state_q != WK_DONE) && (state_q != WK_ERR);
  assign in_payload  = (state_q == WK_PAY);
  assign done        = (state_q == WK_DONE);
  assign error       = (state_q == WK_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WK_IDLE;
      sig_idx_q   <= '0;
      hdr_cnt_q   <= '0;
      len_acc_q   <= '0;
      len_left_q  <= '0;
      is_pay_q    <= 1'b0;
      skip_left_q <= '0;
      payload_len <= '0;
    end else if (start) begin
      state_q     <= cfg_ok ? WK_SIG : WK_ERR;
      sig_idx_q   <= '0;
      hdr_cnt_q   <= '0;
      len_acc_q   <= '0;
      payload_len <= '0;
    end else begin
      case (state_q)
        WK_SIG: begin
          if (kb) begin
            if (byte_data != sig_byte(sig_idx_q))
              state_q <= WK_ERR;
            else if (sig_idx_q == 4'(SIG_BYTES - 1))
              state_q <= WK_TYPE;
            else
              sig_idx_q <= sig_idx_q + 4'd1;
          end
        end
        WK_TYPE: begin
          if (limit_hit) begin
            state_q <= WK_ERR;
          end else if (kb) begin
            hdr_cnt_q <= hdr_cnt_q + CNT_W'(1);
            if (!type_ok) begin
              state_q <= WK_ERR;
            end else begin
              is_pay_q   <= (byte_data == SEC_TYPE_PAY);
              len_left_q <= (byte_data == SEC_TYPE_PAY) ? 2'd3 : 2'd1;
              len_acc_q  <= '0;
              state_q    <= WK_LEN;
            end
          end
        end
        WK_LEN: begin
          if (kb) begin
            len_acc_q <= len_next[23:0];
            if (!is_pay_q)
              hdr_cnt_q <= hdr_cnt_q + CNT_W'(1);
            if (len_left_q != 2'd0) begin
              len_left_q <= len_left_q - 2'd1;
            end else if (is_pay_q) begin
              payload_len <= len_next;
              state_q     <= (len_next == '0) ? WK_DONE : WK_PAY;
            end else if (len_next[PLEN_W-1:8] != '0) begin
              state_q <= WK_ERR;
            end else if (len_next[7:0] == 8'd0) begin
              state_q <= WK_TYPE;
            end else begin
              skip_left_q <= len_next[7:0];
              state_q     <= WK_SKIP;
            end
          end
        end
        WK_SKIP: begin
          if (limit_hit) begin
            state_q <= WK_ERR;
          end else if (kb) begin
            hdr_cnt_q   <= hdr_cnt_q + CNT_W'(1);
            skip_left_q <= skip_left_q - 8'd1;
            if (skip_left_q == 8'd1)
              state_q <= WK_TYPE;
          end
        end
        WK_PAY: begin
          if (kb && pay_last)
            state_q <= WK_DONE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

endmodule

// File: rtl/cfg_image_extract.sv
`timescale 1ns/1ps
module cfg_image_extract
  import imgsel_pkg::*;
#(
  parameter int CHUNK_BYTES  = 288,
  parameter int MAX_IMAGES   = 4,
  parameter int SEARCH_LIMIT = 100,
  localparam int IMG_W = $clog2(MAX_IMAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IMG_W-1:0]  img_sel,
  input  logic [IMG_W-1:0]  img_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic              error,
  output logic [PLEN_W-1:0] payload_length
);

  logic              keep;
  logic              beat;
  logic              cfg_ok;
  logic              wk_ready;
  logic              wk_active;
  logic              wk_payload;
  logic              pay_load;
  logic [PLEN_W-1:0] pay_len_new;
  logic              pay_dec;
  logic              pay_last;

  assign cfg_ok = (img_count != '0) && (img_sel != '0) &&
                  (img_sel <= img_count) && (img_count <= IMG_W'(MAX_IMAGES));

  assign in_ready  = wk_active && (!keep || wk_ready);
  assign beat      = in_valid && in_ready;
  assign out_valid = wk_payload && in_valid && keep;
  assign out_data  = in_data;

  imgsel_chunk_filter #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .MAX_IMAGES  (MAX_IMAGES)
  ) filter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start),
    .sel_in   (img_sel),
    .count_in (img_count),
    .beat     (beat),
    .keep     (keep)
  );

  imgsel_hdr_walker #(
    .SEARCH_LIMIT (SEARCH_LIMIT)
  ) walker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_ok      (cfg_ok),
    .byte_valid  (in_valid && keep),
    .byte_data   (in_data),
    .sink_ready  (out_ready),
    .pay_last    (pay_last),
    .byte_ready  (wk_ready),
    .pay_load    (pay_load),
    .pay_len_new (pay_len_new),
    .pay_dec     (pay_dec),
    .payload_len (payload_length),
    .active      (wk_active),
    .in_payload  (wk_payload),
    .done        (done),
    .error       (error)
  );

  imgsel_pay_count #(
    .LEN_W (PLEN_W)
  ) paycnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pay_load),
    .load_val (pay_len_new),
    .dec      (pay_dec),
    .last     (pay_last)
  );

endmodule

// File: rtl/imgsel_extract_chk.sv
`timescale 1ns/1ps
module imgsel_extract_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        done,
  input logic        error,
  input logic [31:0] payload_length
);

  assert_out_needs_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  assert_stall_holds_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_quiet_when_finished_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!in_ready && !out_valid));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (payload_length == 32'd0 && !done));

  assert_length_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !start) |=> $stable(payload_length));

endmodule

bind cfg_image_extract imgsel_extract_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .done           (done),
  .error          (error),
  .payload_length (payload_length)
);

// File: tb/cfg_image_extract_tb.sv
`timescale 1ns/1ps
module cfg_image_extract_tb_top;

  localparam int C    = 8;
  localparam int MAXI = 3;
  localparam int IW   = $clog2(MAXI + 1);
  localparam int CASE_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] img_sel = '0;
  logic [IW-1:0] img_count = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          done;
  logic          error;
  logic [31:0]   payload_length;

  always #5 clk = ~clk;

  cfg_image_extract #(.CHUNK_BYTES(C), .MAX_IMAGES(MAXI), .SEARCH_LIMIT(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_sel(img_sel), .img_count(img_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .error(error), .payload_length(payload_length)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] simg [0:2047];
  int sim_len = 0;
  int cur_n = 1;
  int cur_sel = 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit keep_exp(input int i);
    return ((i / C) % cur_n) == (cur_sel - 1);
  endfunction

  function automatic logic [7:0] stream_byte(input int i);
    int k;
    int off;
    k = (i / C) % cur_n;
    if (k == cur_sel - 1) begin
      off = (i / (C * cur_n)) * C + (i % C);
      return (off < sim_len) ? simg[off] : 8'h5A;
    end
    return 8'(k * 29 + i * 7 + 3);
  endfunction

  function automatic bit pat(input int cyc, input int p);
    if (p == 0) return 1'b1;
    return ((cyc * 7 + p * 3) % (p + 2)) != 0;
  endfunction

  task automatic put(input logic [7:0] b);
    simg[sim_len] = b;
    sim_len++;
  endtask

  task automatic put_sig(input int bad_pos);
    logic [7:0] s [0:12];
    s = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    for (int j = 0; j < 13; j++) put((j == bad_pos) ? (s[j] ^ 8'h40) : s[j]);
  endtask

  task automatic put_sec(input logic [7:0] t, input int len);
    put(t);
    put(8'(len >> 8));
    put(8'(len));
    for (int j = 0; j < len; j++) put(8'(j * 3) + t);
  endtask

  task automatic put_pay(input int len);
    put(8'h65);
    put(8'(len >> 24)); put(8'(len >> 16)); put(8'(len >> 8)); put(8'(len));
    for (int j = 0; j < len; j++) put(8'(j * 13 + 5));
  endtask

  // Standard header: sig + a(3) b(2) c(0) d(1); payload section follows.
  task automatic std_hdr();
    sim_len = 0;
    put_sig(-1);
    put_sec(8'h61, 3);
    put_sec(8'h62, 2);
    put_sec(8'h63, 0);
    put_sec(8'h64, 1);
  endtask

  task automatic run_case(input int sel, input int n, input int vpat, input int rpat,
                          input bit exp_err, input int exp_len, input int hdr_bytes,
                          input int err_kept, input string req);
    int in_idx;
    int kept;
    int outs;
    int cyc;
    bit kp;
    cur_n   = (n < 1) ? 1 : n;
    cur_sel = sel;
    @(negedge clk);
    start = 1'b1; img_sel = IW'(sel); img_count = IW'(n); in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(payload_length == 0, "R10 start clears length", payload_length, 0);
    in_idx = 0; kept = 0; outs = 0; cyc = 0;
    while (cyc < CASE_CYC) begin
      in_valid  = pat(cyc, vpat);
      in_data   = stream_byte(in_idx);
      out_ready = pat(cyc + 1, rpat);
      #1;
      if (done || error) break;
      kp = keep_exp(in_idx);
      if (in_valid && !kp)
        chk(in_ready == 1'b1, "R1 foreign byte dropped", in_ready, 1);
      if (!kp || (in_valid && kept < hdr_bytes))
        chk(out_valid == 1'b0, "R1 no output of foreign or header byte", out_valid, 0);
      if (in_valid && kp && kept >= hdr_bytes && !exp_err) begin
        chk(out_valid == 1'b1, "R8 payload byte offered", out_valid, 1);
        if (!out_ready) chk(in_ready == 1'b0, "R8 back-pressure stalls input", in_ready, 0);
      end
      if (out_valid && out_ready) begin
        chk(out_data == simg[hdr_bytes + outs], "R7 payload byte", out_data, simg[hdr_bytes + outs]);
        outs++;
      end
      if (in_valid && in_ready) begin
        in_idx++;
        if (kp) kept++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < CASE_CYC, {req, " case finished"}, cyc, CASE_CYC);
    chk(error == exp_err, {req, " error flag"}, error, exp_err);
    chk(done == !exp_err, {req, " done flag"}, done, !exp_err);
    if (!exp_err) begin
      chk(payload_length == 32'(exp_len), "R7 reported length", payload_length, exp_len);
      chk(outs == exp_len, "R7 forwarded byte count", outs, exp_len);
    end
    if (err_kept >= 0)
      chk(kept == err_kept, {req, " kept bytes at stop"}, kept, err_kept);
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10 input stalled after end", in_ready, 0);
    @(negedge clk);
    #1;
    chk(error == exp_err && done == !exp_err, "R10 status holds", {done, error}, {!exp_err, exp_err});
    in_valid = 1'b0;
  endtask

  initial begin
    int plen;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !error && !in_ready && !out_valid && payload_length == 0,
        "R11 reset state", {done, error, in_ready, out_valid}, 0);
    rst_n = 1'b1;

    // Sweep every legal image selection for 1..3 images (R1, R3, R7, R8).
    for (int n = 1; n <= MAXI; n++) begin
      for (int s = 1; s <= n; s++) begin
        plen = 3 + 11 * s + 5 * n;
        std_hdr();
        put_pay(plen);
        run_case(s, n, n - 1 + s, (s + n) % 3, 1'b0, plen, 36, -1, "R3 sections walked");
      end
    end

    // Multi-byte big-endian payload length (R7).
    std_hdr(); put_pay(261);
    run_case(3, 3, 2, 1, 1'b0, 261, 36, -1, "R7 long payload");

    // Zero payload length (R7).
    std_hdr(); put_pay(0);
    run_case(2, 2, 0, 0, 1'b0, 0, 36, 36, "R7 empty payload");

    // Signature mismatch at every position (R2).
    for (int p = 0; p < 13; p++) begin
      sim_len = 0; put_sig(p); put_sec(8'h61, 1); put_pay(4);
      run_case(2, 2, p % 3, 0, 1'b1, 0, 1000, p + 1, "R2 signature mismatch");
    end

    // Type byte outside range, both sides (R4).
    sim_len = 0; put_sig(-1); put_sec(8'h61, 3); put(8'h66); put_pay(2);
    run_case(1, 3, 1, 0, 1'b1, 0, 1000, 20, "R4 type above range");
    sim_len = 0; put_sig(-1); put_sec(8'h61, 3); put(8'h60); put_pay(2);
    run_case(3, 3, 0, 0, 1'b1, 0, 1000, 20, "R4 type below range");

    // Length boundary on a 2-byte section (R5, R6).
    sim_len = 0; put_sig(-1); put_sec(8'h61, 256); put_pay(2);
    run_case(1, 2, 0, 0, 1'b1, 0, 1000, 16, "R5 length 256 rejected");
    sim_len = 0; put_sig(-1); put_sec(8'h61, 255); put_pay(2);
    run_case(1, 2, 0, 0, 1'b1, 0, 1000, 113, "R6 length 255 runs into limit");

    // Search limit edge: payload type at header byte 99 found, at 100 refused (R6).
    sim_len = 0; put_sig(-1); put_sec(8'h62, 96); put_pay(6);
    run_case(2, 3, 1, 2, 1'b0, 6, 117, -1, "R6 type at last allowed byte");
    sim_len = 0; put_sig(-1); put_sec(8'h62, 97); put_pay(6);
    run_case(2, 3, 0, 0, 1'b1, 0, 1000, 113, "R6 type past limit");

    // Illegal configurations (R9).
    std_hdr(); put_pay(3);
    run_case(0, 2, 0, 0, 1'b1, 0, 1000, 0, "R9 select zero");
    run_case(3, 2, 0, 0, 1'b1, 0, 1000, 0, "R9 select above count");
    run_case(1, 0, 0, 0, 1'b1, 0, 1000, 0, "R9 count zero");

    // Restart after an error recovers (R10).
    std_hdr(); put_pay(9);
    run_case(1, 1, 0, 0, 1'b0, 9, 36, -1, "R10 restart after error");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule